// File: doc/BRIEF.md
# PLL Lock Timer and Control

This block sits beside a clock-multiplier PLL and owns its programming. It stores the multiplier, the startup mode and a lock-count value, and it drives the PLL enable and parameter pins from them. The PLL is switched off by a multiplier of zero and switched on by any other multiplier.

The block does not detect lock from the PLL itself. When the PLL is turned on or any of its settings changes, the lock flag drops and a down-counter is loaded. The counter steps once per rising edge of a slow reference clock. When it runs out, the lock flag rises. In fast-startup mode the counter is always loaded with one, whatever count software wrote. A lock interrupt follows the lock flag when its enable bit is set.

Software reaches the block through a simple write port and a combinational read port in the bus clock domain. The slow clock is an asynchronous input. It is synchronised inside the block and only its rising edges count.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pll_en`, `lock` and `lock_irq` are 0. Register 0 reads back 0x200, which is multiplier 0, mode 2 and count 0.
- R2: Register 0 holds the count in bits [7:0], the mode in bits [9:8] and the multiplier in bits [20:10]. It reads back as written, except as R3 states. `pll_mult` and `pll_mode` show the stored fields. `pll_en` is 1 exactly when the stored multiplier is nonzero.
- R3: A write to register 0 with multiplier 0 stores mode 2 whatever mode was written. The same write turns the PLL off and clears `lock`. `lock` then stays 0 through any number of slow clock edges.
- R4: In mode 2, or in reserved modes 1 and 3, with a count N of 1 or more, `lock` stays 0 through N-1 slow clock rising edges after the enabling write. It becomes 1 after the Nth edge.
- R5: A count of 0 behaves as a count of 1.
- R6: In mode 0 (fast startup), `lock` becomes 1 after the first slow clock rising edge, whatever count was written. The written count still reads back unchanged.
- R7: A write with a nonzero multiplier that changes any field of register 0 clears `lock` in the cycle after the write. It also restarts the countdown from the new settings.
- R8: A write to register 0 made while the countdown is running restarts it from the newly written count, even if the value is the same.
- R9: A write that repeats the current register 0 value while `lock` is 1 leaves `lock` at 1.
- R10: Register 1 bit 0 is the interrupt enable and bit 1 reads the lock flag. `lock_irq` equals `lock` AND the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk | input | 1 | Asynchronous slow reference clock; rising edges advance the countdown |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 configuration, 1 interrupt control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 32 | Read data, combinational on `rd_addr` |
| pll_en | output | 1 | PLL enable |
| pll_mult | output | 11 | Multiplier driven to the PLL |
| pll_mode | output | 2 | Startup mode driven to the PLL |
| lock | output | 1 | Lock flag |
| lock_irq | output | 1 | Lock interrupt |

## Verification
The countdown is driven from a table of settings that covers:
- counts of several sizes in normal mode, which show whether the counter counts the right number of edges;
- a count of zero, which separates a zero-means-one counter from one that never locks or wraps;
- a large count in fast mode, which shows whether the mode overrides the count;
- a reserved mode value.

Directed sequences then cover:
- a repeated identical write against a changed write, which separates real reconfiguration from a blind restart;
- a rewrite in the middle of a count, which shows whether the new value or the old remainder is used;
- a shutdown write, which shows the forced mode and that the flag stays low.

// File: rtl/pll_lock_pkg.sv
// Shared definitions for the PLL lock timer: register addresses and
// startup mode codes. Assumes a one-bit register address space.
package pll_lock_pkg;

    localparam logic REG_CFG = 1'b0;
    localparam logic REG_IRQ = 1'b1;

    typedef enum logic [1:0] {
        MODE_FAST   = 2'd0,
        MODE_RSVD1  = 2'd1,
        MODE_NORMAL = 2'd2,
        MODE_RSVD3  = 2'd3
    } pll_mode_e;

endpackage

// File: rtl/pll_tick_sync.sv
// Brings the asynchronous slow clock into the bus clock domain and emits a
// one-cycle tick for each rising edge. Assumes the slow clock is far slower
// than the bus clock (several bus cycles per level). SYNC_STAGES >= 2.
module pll_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic tick
);

    logic [SYNC_STAGES:0] sync_q;

    // Shift the slow clock level through the synchroniser and edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], slow_clk};
        end
    end

    // Rising edge of the synchronised level.
    assign tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

endmodule

// File: rtl/pll_cfg_regs.sv
// Configuration and interrupt-enable storage. Decodes writes and decides
// when the lock countdown must stop (multiplier zero) or restart
// (reconfiguration, or any write during a countdown). Forces normal startup
// mode whenever the PLL is shut down.
module pll_cfg_regs
    import pll_lock_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int MULT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              counting,
    output logic [MULT_W-1:0] mult_q,
    output logic [1:0]        mode_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              ie_q,
    output logic              restart,
    output logic              stop,
    output logic [CNT_W-1:0]  load_val
);

    localparam int CFG_W = CNT_W + 2 + MULT_W;

    logic [CNT_W-1:0]  new_cnt;
    logic [1:0]        new_mode;
    logic [MULT_W-1:0] new_mult;
    logic              cfg_wr;
    logic              differs;
    logic              unused_hi;

    assign new_cnt   = wr_data[CNT_W-1:0];
    assign new_mode  = wr_data[CNT_W +: 2];
    assign new_mult  = wr_data[CNT_W+2 +: MULT_W];
    assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

    // Decode the configuration write and the countdown control pulses.
    always_comb begin
        cfg_wr   = wr_en && (wr_addr == REG_CFG);
        differs  = {new_mult, new_mode, new_cnt} != {mult_q, mode_q, cnt_q};
        stop     = cfg_wr && (new_mult == '0);
        restart  = cfg_wr && (new_mult != '0) && (differs || counting);
        load_val = (new_mode == MODE_FAST) ? CNT_W'(1) : new_cnt;
    end

    // Store the configuration fields; shutdown forces normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q <= '0;
            mode_q <= MODE_NORMAL;
            cnt_q  <= '0;
        end else if (cfg_wr) begin
            mult_q <= new_mult;
            mode_q <= (new_mult == '0) ? MODE_NORMAL : new_mode;
            cnt_q  <= new_cnt;
        end
    end

    // Store the interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (wr_en && (wr_addr == REG_IRQ)) begin
            ie_q <= wr_data[0];
        end
    end

endmodule

// File: rtl/pll_lock_counter.sv
// Lock countdown. A restart loads the count and clears lock; each tick
// decrements it; reaching zero sets lock. A loaded zero behaves as one.
// Stop has priority over restart, restart over tick.
module pll_lock_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             stop,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             lock_q,
    output logic             busy_q
);

    logic [CNT_W-1:0] remain_q;

    // Run the countdown and raise the lock flag at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            busy_q   <= 1'b0;
            lock_q   <= 1'b0;
        end else if (stop) begin
            remain_q <= '0;
            busy_q   <= 1'b0;
            lock_q   <= 1'b0;
        end else if (restart) begin
            remain_q <= load_val;
            busy_q   <= 1'b1;
            lock_q   <= 1'b0;
        end else if (busy_q && tick) begin
            if (remain_q <= CNT_W'(1)) begin
                remain_q <= '0;
                busy_q   <= 1'b0;
                lock_q   <= 1'b1;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pll_lock_ctrl.sv
// PLL lock timer and control top. Holds the PLL settings, drives the PLL
// enable and parameters, and declares lock after a programmable number of
// slow clock rising edges. Assumes CNT_W + 2 + MULT_W < DATA_W.
module pll_lock_ctrl
    import pll_lock_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8,
    parameter int MULT_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pll_en,
    output logic [MULT_W-1:0] pll_mult,
    output logic [1:0]        pll_mode,
    output logic              lock,
    output logic              lock_irq
);

    localparam int CFG_W = CNT_W + 2 + MULT_W;

    logic              tick;
    logic              restart;
    logic              stop;
    logic              busy;
    logic              ie;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  load_val;

    pll_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_clk (slow_clk),
        .tick     (tick)
    );

    pll_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MULT_W(MULT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .counting (busy),
        .mult_q   (pll_mult),
        .mode_q   (pll_mode),
        .cnt_q    (cnt),
        .ie_q     (ie),
        .restart  (restart),
        .stop     (stop),
        .load_val (load_val)
    );

    pll_lock_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .stop     (stop),
        .tick     (tick),
        .load_val (load_val),
        .lock_q   (lock),
        .busy_q   (busy)
    );

    assign pll_en   = (pll_mult != '0);
    assign lock_irq = lock & ie;

    // Return the addressed register contents.
    always_comb begin
        if (rd_addr == REG_CFG) begin
            rd_data = DATA_W'({pll_mult, pll_mode, cnt});
        end else begin
            rd_data = DATA_W'({lock, ie});
        end
    end

endmodule

// File: rtl/pll_lock_ctrl_chk.sv
// Property checker for pll_lock_ctrl, attached by bind. Observes ports only.
module pll_lock_ctrl_chk #(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8,
    parameter int MULT_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_clk,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              pll_en,
    input logic [MULT_W-1:0] pll_mult,
    input logic [1:0]        pll_mode,
    input logic              lock,
    input logic              lock_irq
);

    // R3
    lock_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> pll_en);

    // R3
    shutdown_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && (wr_data[CNT_W+2 +: MULT_W] == '0))
        |=> (!pll_en && (pll_mode == 2'd2) && !lock));

    // R7
    reconfig_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && (wr_data[CNT_W+2 +: MULT_W] != pll_mult))
        |=> !lock);

    // R2
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_addr) |=> ($stable(pll_mult) && $stable(pll_mode)));

    // R4
    no_lock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> !$rose(lock));

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_irq |-> lock);

endmodule

bind pll_lock_ctrl pll_lock_ctrl_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MULT_W(MULT_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/pll_lock_ctrl_test.sv
// Self-checking bench for pll_lock_ctrl: table-driven countdown tests,
// then directed reset and corner-case sequences.
module pll_lock_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        pll_en;
    logic [10:0] pll_mult;
    logic [1:0]  pll_mode;
    logic        lock;
    logic        lock_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pll_lock_ctrl uut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pll_en(pll_en), .pll_mult(pll_mult), .pll_mode(pll_mode),
        .lock(lock), .lock_irq(lock_irq)
    );

    // Vector: {mult[10:0], mode[1:0], count[7:0], edges_to_lock[3:0]}
    localparam int NVEC = 6;
    localparam logic [24:0] VECS [NVEC] = '{
        {11'd1, 2'd2, 8'd3, 4'd3},   // R4 normal, count 3
        {11'd2, 2'd2, 8'd1, 4'd1},   // R4 normal, count 1
        {11'd3, 2'd2, 8'd0, 4'd1},   // R5 zero behaves as one
        {11'd4, 2'd0, 8'd9, 4'd1},   // R6 fast mode ignores count
        {11'd5, 2'd2, 8'd6, 4'd6},   // R4 normal, count 6
        {11'd6, 2'd3, 8'd2, 4'd2}    // R4 reserved mode counts normally
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_read(input logic addr, output logic [31:0] data);
        @(negedge clk);
        rd_addr = addr;
        #1 data = rd_data;
    endtask

    task automatic slow_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_clk = 1'b1;
            repeat (4) @(negedge clk);
            slow_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pll_en", {31'd0, pll_en}, 32'd0);
        check("R1 lock", {31'd0, lock}, 32'd0);
        check("R1 lock_irq", {31'd0, lock_irq}, 32'd0);
        reg_read(1'b0, rd);
        check("R1 cfg readback", rd, 32'h200);
        @(negedge clk); rst_n = 1'b1;
        reg_read(1'b0, rd);
        check("R1 cfg after release", rd, 32'h200);

        // Table walk: R2 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            reg_write(1'b0, {11'd0, VECS[v][24:4]});
            check("R7 lock cleared by write", {31'd0, lock}, 32'd0);
            check("R2 pll_en", {31'd0, pll_en}, 32'd1);
            check("R2 pll_mult", {21'd0, pll_mult}, {21'd0, VECS[v][24:14]});
            check("R2 pll_mode", {30'd0, pll_mode}, {30'd0, VECS[v][13:12]});
            reg_read(1'b0, rd);
            check("R2 R6 cfg readback", rd, {11'd0, VECS[v][24:4]});
            slow_edges(int'(VECS[v][3:0]) - 1);
            check("R4 lock before last edge", {31'd0, lock}, 32'd0);
            slow_edges(1);
            check("R4 R5 R6 lock after last edge", {31'd0, lock}, 32'd1);
        end

        // R9 identical write keeps lock
        reg_write(1'b0, {11'd0, 11'd6, 2'd3, 8'd2});
        check("R9 lock kept", {31'd0, lock}, 32'd1);

        // R10 interrupt gating and status read
        check("R10 irq masked", {31'd0, lock_irq}, 32'd0);
        reg_write(1'b1, 32'd1);
        check("R10 irq enabled", {31'd0, lock_irq}, 32'd1);
        reg_read(1'b1, rd);
        check("R10 status read", rd, 32'd3);

        // R7 changed mode clears lock and restarts
        reg_write(1'b0, {11'd0, 11'd6, 2'd2, 8'd2});
        check("R7 lock cleared", {31'd0, lock}, 32'd0);
        check("R10 irq follows lock", {31'd0, lock_irq}, 32'd0);
        slow_edges(1);
        check("R7 still counting", {31'd0, lock}, 32'd0);
        slow_edges(1);
        check("R7 relocked", {31'd0, lock}, 32'd1);

        // R8 rewrite mid-count restarts from new value
        reg_write(1'b0, {11'd0, 11'd6, 2'd2, 8'd4});
        slow_edges(2);
        reg_write(1'b0, {11'd0, 11'd6, 2'd2, 8'd3});
        check("R8 lock low after rewrite", {31'd0, lock}, 32'd0);
        slow_edges(2);
        check("R8 not locked from old remainder", {31'd0, lock}, 32'd0);
        slow_edges(1);
        check("R8 locked after new count", {31'd0, lock}, 32'd1);

        // R3 shutdown forces mode 2 and holds lock low
        reg_write(1'b0, {11'd0, 11'd0, 2'd0, 8'd5});
        check("R3 pll_en off", {31'd0, pll_en}, 32'd0);
        check("R3 mode forced", {30'd0, pll_mode}, 32'd2);
        check("R3 lock cleared", {31'd0, lock}, 32'd0);
        reg_read(1'b0, rd);
        check("R3 cfg readback", rd, 32'h205);
        slow_edges(3);
        check("R3 lock stays low", {31'd0, lock}, 32'd0);
        check("R3 irq stays low", {31'd0, lock_irq}, 32'd0);

        finish_run();
    end

endmodule